// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a branch is taken, using the five status flags left by the most recent flag-setting operation: sign, zero, carry, overflow and parity. A 4-bit condition code names one of eight base tests. The code's lowest bit asks for the logical opposite of that test. A separate input marks an unconditional jump, which is taken whatever the flags and the code say.

The unit is purely combinational and holds no state. It sits between the flag register and the fetch redirect logic. The usual case is a compare, which subtracts one operand from another only to set the flags, followed by a conditional branch. The flags alone are enough to resolve both signed and unsigned orderings. The unsigned tests use carry and zero. The signed tests use the exclusive-OR of sign and overflow, together with zero.

Top module: `branch_cond_eval`

## Requirements
- R1: With cond_code[3:1] = 3'b000 (overflow test) and cond_code[0] = 0, taken equals flag_ovf.
- R2: With cond_code[3:1] = 3'b101 (parity test) and cond_code[0] = 0, taken equals flag_par, where flag_par = 1 means the result had an even number of ones.
- R3: With cond_code[0] = 0, selector 3'b100 (sign test) gives taken = flag_sign, and selector 3'b010 (equal test) gives taken = flag_zero.
- R4: With cond_code[0] = 0, selector 3'b001 (below) gives taken = flag_carry, and selector 3'b011 (below-or-equal) gives taken = flag_carry | flag_zero.
- R5: With cond_code[0] = 0, selector 3'b110 (less) gives taken = flag_sign ^ flag_ovf, and selector 3'b111 (less-or-equal) gives taken = (flag_sign ^ flag_ovf) | flag_zero.
- R6: With cond_code[0] = 1 and uncond = 0, taken is the complement of the base test chosen by cond_code[3:1].
- R7: With uncond = 1, taken = 1 for every flag value and every cond_code.
- R8: After the flags are set by computing a minus b, selectors below and below-or-equal resolve to a < b and a <= b for unsigned operands, and their inverses resolve to a >= b and a > b.
- R9: After the flags are set by computing a minus b, selectors less and less-or-equal resolve to a < b and a <= b for two's complement operands, and their inverses resolve to a >= b and a > b.
- R10: taken depends only on the present inputs. The same inputs give the same output whatever inputs were applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flag_sign | input | 1 | Result was negative (most significant bit set) |
| flag_zero | input | 1 | Result was exactly zero |
| flag_carry | input | 1 | Carry out or borrow from the last operation |
| flag_ovf | input | 1 | Two's complement overflow |
| flag_par | input | 1 | Result had even parity |
| cond_code | input | 4 | [3:1] base test selector, [0] invert request |
| uncond | input | 1 | Unconditional jump; forces taken |
| taken | output | 1 | Branch is taken |

## Verification
The assertions check implications between base tests that hold for every flag pattern, for example below implies below-or-equal. They therefore assume only that the flag inputs are driven to known values. They do not assume the flags came from a real subtraction. The stimulus therefore mixes flag vectors derived from actual signed and unsigned compares with fully random flag vectors, including patterns that no subtraction can produce, such as zero set together with sign. The inverted codes and the unconditional input are applied over both kinds of vector.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;

    localparam int COND_W = 4;
    localparam int SEL_W  = COND_W - 1;
    localparam int N_BASE = 1 << SEL_W;

    typedef struct packed {
        logic sign;
        logic zero;
        logic carry;
        logic ovf;
        logic par;
    } flags_t;

    typedef enum logic [SEL_W-1:0] {
        BC_OVF      = 3'd0,
        BC_BELOW    = 3'd1,
        BC_EQ       = 3'd2,
        BC_BELOW_EQ = 3'd3,
        BC_SIGN     = 3'd4,
        BC_PAR      = 3'd5,
        BC_LESS     = 3'd6,
        BC_LESS_EQ  = 3'd7
    } base_sel_e;

    typedef struct packed {
        base_sel_e sel;
        logic      invert;
    } cond_t;

    function automatic logic signed_lt(flags_t f);
        return f.sign ^ f.ovf;
    endfunction

    function automatic logic base_test(base_sel_e s, flags_t f);
        case (s)
            BC_OVF:      return f.ovf;
            BC_BELOW:    return f.carry;
            BC_EQ:       return f.zero;
            BC_BELOW_EQ: return f.carry | f.zero;
            BC_SIGN:     return f.sign;
            BC_PAR:      return f.par;
            BC_LESS:     return signed_lt(f);
            default:     return signed_lt(f) | f.zero;
        endcase
    endfunction

endpackage

// File: rtl/cond_decode.sv
module cond_decode
    import branch_cond_pkg::*;
(
    input  logic [COND_W-1:0] code,
    output cond_t             dec
);
    always_comb begin
        dec.sel    = base_sel_e'(code[COND_W-1:1]);
        dec.invert = code[0];
    end
endmodule

// File: rtl/cond_base_eval.sv
module cond_base_eval
    import branch_cond_pkg::*;
(
    input  flags_t            flags,
    output logic [N_BASE-1:0] base_vec
);
    for (genvar i = 0; i < N_BASE; i++) begin : g_test
        assign base_vec[i] = base_test(base_sel_e'(SEL_W'(i)), flags);
    end

    // Ordering relations between independent test cells
    always_comb begin
        a_r4_below_in_below_eq: assert (!base_vec[BC_BELOW] || base_vec[BC_BELOW_EQ])
            else $error("R4: below set without below-or-equal");
        a_r4_eq_in_below_eq: assert (!base_vec[BC_EQ] || base_vec[BC_BELOW_EQ])
            else $error("R4: equal set without below-or-equal");
        a_r5_less_in_less_eq: assert (!base_vec[BC_LESS] || base_vec[BC_LESS_EQ])
            else $error("R5: less set without less-or-equal");
        a_r5_eq_in_less_eq: assert (!base_vec[BC_EQ] || base_vec[BC_LESS_EQ])
            else $error("R5: equal set without less-or-equal");
    end
endmodule

// File: rtl/cond_resolve.sv
module cond_resolve
    import branch_cond_pkg::*;
(
    input  logic [N_BASE-1:0] base_vec,
    input  cond_t             dec,
    input  logic              uncond,
    output logic              taken
);
    logic picked;

    always_comb begin
        picked = base_vec[dec.sel];
        taken  = uncond | (picked ^ dec.invert);
    end

    always_comb begin
        a_r7_uncond_taken: assert (!uncond || taken)
            else $error("R7: unconditional jump not taken");
        a_r6_plain_follows_base: assert (uncond || dec.invert || (taken == base_vec[dec.sel]))
            else $error("R6: plain code does not follow base test");
    end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import branch_cond_pkg::*;
(
    input  logic              flag_sign,
    input  logic              flag_zero,
    input  logic              flag_carry,
    input  logic              flag_ovf,
    input  logic              flag_par,
    input  logic [COND_W-1:0] cond_code,
    input  logic              uncond,
    output logic              taken
);
    flags_t            flags;
    cond_t             dec;
    logic [N_BASE-1:0] base_vec;

    assign flags = '{sign: flag_sign, zero: flag_zero, carry: flag_carry,
                     ovf: flag_ovf, par: flag_par};

    cond_decode u_decode (
        .code (cond_code),
        .dec  (dec)
    );

    cond_base_eval u_base (
        .flags    (flags),
        .base_vec (base_vec)
    );

    cond_resolve u_resolve (
        .base_vec (base_vec),
        .dec      (dec),
        .uncond   (uncond),
        .taken    (taken)
    );

    always_comb begin
        a_r6_inverse_pair: assert (uncond || !dec.invert || (taken != base_vec[dec.sel]))
            else $error("R6: inverted code equals base test");
    end
endmodule

// File: tb/branch_cond_eval_tb.sv
module branch_cond_eval_tb;

    localparam int OPW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       f_s, f_z, f_c, f_o, f_p;
    logic [3:0] code;
    logic       unc;
    logic       taken;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    branch_cond_eval u_dut (
        .flag_sign  (f_s),
        .flag_zero  (f_z),
        .flag_carry (f_c),
        .flag_ovf   (f_o),
        .flag_par   (f_p),
        .cond_code  (code),
        .uncond     (unc),
        .taken      (taken)
    );

    // Flag-level model from R1..R6
    function automatic logic flag_model(logic [3:0] c, logic s, logic z, logic cy, logic o, logic p);
        logic b;
        case (c[3:1])
            3'd0: b = o;
            3'd1: b = cy;
            3'd2: b = z;
            3'd3: b = cy | z;
            3'd4: b = s;
            3'd5: b = p;
            3'd6: b = s ^ o;
            default: b = (s ^ o) | z;
        endcase
        return b ^ c[0];
    endfunction

    task automatic check(string req, logic exp);
        #1;
        n_chk++;
        if (taken !== exp) begin
            n_bad++;
            $display("FAIL %s: code=%b unc=%b flags s%b z%b c%b o%b p%b got=%b exp=%b",
                     req, code, unc, f_s, f_z, f_c, f_o, f_p, taken, exp);
        end
        #1;
    endtask

    task automatic set_flags(logic [4:0] v);
        {f_s, f_z, f_c, f_o, f_p} = v;
    endtask

    // Drive flags as a subtraction a - b would set them, then check relations (R8, R9)
    task automatic cmp_pair(logic [OPW-1:0] a, logic [OPW-1:0] b);
        logic [OPW:0] d;
        d   = {1'b0, a} - {1'b0, b};
        f_c = d[OPW];
        f_z = (d[OPW-1:0] == '0);
        f_s = d[OPW-1];
        f_o = (a[OPW-1] != b[OPW-1]) && (d[OPW-1] != a[OPW-1]);
        f_p = ~^d[7:0];
        unc = 1'b0;
        code = 4'b0010; check("R8", a < b);
        code = 4'b0011; check("R8", a >= b);
        code = 4'b0110; check("R8", a <= b);
        code = 4'b0111; check("R8", a > b);
        code = 4'b1100; check("R9", $signed(a) <  $signed(b));
        code = 4'b1101; check("R9", $signed(a) >= $signed(b));
        code = 4'b1110; check("R9", $signed(a) <= $signed(b));
        code = 4'b1111; check("R9", $signed(a) >  $signed(b));
        code = 4'b0100; check("R3", a == b);
        code = 4'b0101; check("R6", a != b);
        code = 4'b1000; check("R3", d[OPW-1]);
        code = 4'b1010; check("R2", ~^d[7:0]);
        code = 4'b0000; check("R1", f_o);
    endtask

    initial begin
        void'($urandom(32'd1234));
        set_flags(5'b0); code = '0; unc = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Directed: all flags clear, overflow test not taken (R1)
        code = 4'b0000; check("R1", 1'b0);

        // Exhaustive flags by code, non-inverted and inverted
        for (int v = 0; v < 32; v++) begin
            for (int c = 0; c < 16; c++) begin
                set_flags(5'(v)); code = 4'(c); unc = 1'b0;
                case (c[3:1])
                    3'd0: check(c[0] ? "R6" : "R1", flag_model(code, f_s, f_z, f_c, f_o, f_p));
                    3'd5: check(c[0] ? "R6" : "R2", flag_model(code, f_s, f_z, f_c, f_o, f_p));
                    3'd2, 3'd4: check(c[0] ? "R6" : "R3", flag_model(code, f_s, f_z, f_c, f_o, f_p));
                    3'd1, 3'd3: check(c[0] ? "R6" : "R4", flag_model(code, f_s, f_z, f_c, f_o, f_p));
                    default: check(c[0] ? "R6" : "R5", flag_model(code, f_s, f_z, f_c, f_o, f_p));
                endcase
                unc = 1'b1;
                check("R7", 1'b1);
            end
        end

        // Directed compare corners
        cmp_pair(8'h00, 8'h00);
        cmp_pair(8'h7F, 8'h80);
        cmp_pair(8'h80, 8'h7F);
        cmp_pair(8'hFF, 8'h01);
        cmp_pair(8'h01, 8'hFF);
        cmp_pair(8'h80, 8'h80);
        cmp_pair(8'h80, 8'h01);

        // Random compares
        for (int k = 0; k < 400; k++) begin
            cmp_pair(8'($urandom), 8'($urandom));
        end

        // History independence (R10)
        set_flags(5'b01000); code = 4'b0110; unc = 1'b0;
        check("R10", 1'b1);
        for (int k = 0; k < 20; k++) begin
            set_flags(5'($urandom)); code = 4'($urandom); unc = 1'($urandom);
            #2;
        end
        set_flags(5'b01000); code = 4'b0110; unc = 1'b0;
        check("R10", 1'b1);

        done = 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
    end

    initial begin
        wait (done || cycles >= 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got=timeout exp=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule